// File: doc/BRIEF.md
# Multicast address hash filter

This block filters received Ethernet frames whose destination is a group (multicast) address. It keeps a 256-entry, one-bit-per-entry hash table spread over eight 32-bit words. Each destination address maps to one entry through a CRC-based hash. A frame is accepted only when its address is a group address and the entry its hash selects is set.

Software manages the table in two ways. A register command port writes a word, or ORs or AND-NOTs a mask into a word, and a read port returns any word. A hash update port takes a full 48-bit address and a set or clear flag. It computes the entry itself and changes only that bit.

On the receive side, the destination address arrives one byte per cycle, framed by a start-of-frame strobe. One cycle after the sixth byte is taken, a one-cycle decision pulse comes out together with the accept flag.

Top module: `mcast_hash_filter`

## Requirements
- R1: The hash index of a 48-bit address is computed as follows. A CRC uses polynomial 0x04C11DB7, a register preset to all ones, and no final inversion. It runs over the six bytes in the order mac[47:40] first down to mac[7:0] last, with each byte fed least significant bit first. Index bit 7 equals CRC bit 0, index bit 6 equals CRC bit 1, and so on down to index bit 0, which equals CRC bit 7. This is the top byte of the bit-reversed CRC.
- R2: Index bits [7:5] select table word 0..7. Index bits [4:0], holding value b, select bit 31-b of that word. Entry 0 is bit 31 of word 0, and entry 255 is bit 0 of word 7.
- R3: A hash update with the set flag high sets the selected bit at the clock edge. Every other table bit keeps its value.
- R4: A hash update with the set flag low clears the selected bit at the clock edge. Every other table bit keeps its value.
- R5: A register command changes the selected word at the clock edge according to its op code. Op 2'b00 replaces the word with the data. Op 2'b01 ORs the data into the word. Op 2'b10 clears the bits that are set in the data. Op 2'b11 leaves the word unchanged. The read port returns the word chosen by the read select in the same cycle.
- R6: When a register command and a hash update target the same word in one cycle, only the register command takes effect. When they target different words, both take effect.
- R7: Reset clears all eight table words to zero.
- R8: A byte with rx_valid and rx_sof both high starts a frame and is its first address byte. The next five valid bytes complete the address. Cycles with rx_valid low are skipped. Valid bytes after the sixth byte, and valid bytes before any start strobe, are ignored.
- R9: rx_dec_valid is high for exactly the one cycle after the clock edge that takes the sixth byte. rx_accept is never high while rx_dec_valid is low.
- R10: rx_accept is high only when bit 0 of the first byte is 1 and the table entry indexed by the received address is 1. The table contents used are those in place at the edge that takes the sixth byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_cmd_valid | input | 1 | Register command strobe |
| reg_cmd_op | input | 2 | Command op: write, OR, AND-NOT, no-op |
| reg_cmd_sel | input | 3 | Target word of the command |
| reg_cmd_data | input | 32 | Command data or mask |
| reg_rd_sel | input | 3 | Word to read |
| reg_rd_data | output | 32 | Selected table word |
| hash_upd_valid | input | 1 | Hash update strobe |
| hash_upd_set | input | 1 | 1 sets, 0 clears the hashed entry |
| hash_upd_mac | input | 48 | Address to hash, first byte in [47:40] |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | First destination byte of a frame |
| rx_byte | input | 8 | Destination address byte |
| rx_dec_valid | output | 1 | Decision pulse |
| rx_accept | output | 1 | Frame accepted by the filter |

## Verification
The bound checker watches every cycle for several properties. A hash set or clear that does not collide with a register command must land on the entry the hasher selects. A register write must leave exactly its data in the word, and an OR must leave every mask bit set. It also checks that the decision pulse never lasts two cycles and that accept never appears without it. Some behaviours can only be shown by the bench's scenarios: that the hash matches the CRC definition, that stalls and stray or extra bytes leave the decision unchanged, that unicast addresses are rejected even when their entry is set, that reset clears the table, and that the losing half of a same-word collision has no effect.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
   localparam logic [31:0] CRC_POLY  = 32'h04C1_1DB7;
   localparam logic [31:0] CRC_SEED  = 32'hFFFF_FFFF;
   localparam int          MAC_BYTES = 6;

   typedef enum logic [1:0] {
      CMD_WRITE = 2'b00,
      CMD_OR    = 2'b01,
      CMD_ANDN  = 2'b10,
      CMD_NOP   = 2'b11
   } reg_op_e;

   // One byte through the CRC, least significant bit entering first.
   function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      logic        fb;
      r = c;
      for (int i = 0; i < 8; i++) begin
         fb = r[31] ^ d[i];
         r  = {r[30:0], 1'b0};
         if (fb) r = r ^ CRC_POLY;
      end
      return r;
   endfunction
endpackage

// File: rtl/mhf_hasher.sv
module mhf_hasher
   import mhf_pkg::*;
#(
   parameter int IDX_W = 8
) (
   input  logic [8*MAC_BYTES-1:0] mac,
   output logic [IDX_W-1:0]       idx
);
   logic [31:0] crc;

   always_comb begin
      crc = CRC_SEED;
      for (int n = 0; n < MAC_BYTES; n++)
         crc = crc_step(crc, mac[8*(MAC_BYTES-1-n) +: 8]);
   end

   // Top bits of the reversed CRC equal the low CRC bits in reverse.
   for (genvar k = 0; k < IDX_W; k++) begin : g_rev
      assign idx[IDX_W-1-k] = crc[k];
   end
endmodule

// File: rtl/mhf_table.sv
module mhf_table
   import mhf_pkg::*;
#(
   parameter int NUM_WORDS = 8,
   parameter int WORD_W    = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cmd_valid,
   input  logic [1:0]                    cmd_op,
   input  logic [$clog2(NUM_WORDS)-1:0]  cmd_sel,
   input  logic [WORD_W-1:0]             cmd_data,
   input  logic                          upd_valid,
   input  logic                          upd_set,
   input  logic [$clog2(NUM_WORDS*WORD_W)-1:0] upd_idx,
   input  logic [$clog2(NUM_WORDS)-1:0]  rd_sel,
   output logic [WORD_W-1:0]             rd_data,
   output logic [NUM_WORDS*WORD_W-1:0]   tbl_flat
);
   localparam int SEL_W = $clog2(NUM_WORDS);
   localparam int BIT_W = $clog2(WORD_W);
   localparam int IDX_W = SEL_W + BIT_W;

   logic [SEL_W-1:0]  upd_word;
   logic [WORD_W-1:0] upd_mask;

   assign upd_word = upd_idx[IDX_W-1 -: SEL_W];

   always_comb begin
      upd_mask = '0;
      upd_mask[WORD_W-1-int'(upd_idx[BIT_W-1:0])] = 1'b1;
   end

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      logic [WORD_W-1:0] word_q;
      logic              reg_hit;
      logic              upd_hit;

      assign reg_hit = cmd_valid && (cmd_sel == SEL_W'(w));
      assign upd_hit = upd_valid && (upd_word == SEL_W'(w)) && !reg_hit;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            word_q <= '0;
         end else if (reg_hit) begin
            case (reg_op_e'(cmd_op))
               CMD_WRITE: word_q <= cmd_data;
               CMD_OR:    word_q <= word_q | cmd_data;
               CMD_ANDN:  word_q <= word_q & ~cmd_data;
               default:   word_q <= word_q;
            endcase
         end else if (upd_hit) begin
            word_q <= upd_set ? (word_q | upd_mask) : (word_q & ~upd_mask);
         end
      end

      assign tbl_flat[w*WORD_W +: WORD_W] = word_q;
   end

   assign rd_data = tbl_flat[int'(rd_sel)*WORD_W +: WORD_W];
endmodule

// File: rtl/mhf_rx.sv
module mhf_rx
   import mhf_pkg::*;
#(
   parameter int NUM_WORDS = 8,
   parameter int WORD_W    = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        rx_valid,
   input  logic                        rx_sof,
   input  logic [7:0]                  rx_byte,
   input  logic [NUM_WORDS*WORD_W-1:0] tbl_flat,
   output logic                        dec_valid,
   output logic                        accept
);
   localparam int SEL_W = $clog2(NUM_WORDS);
   localparam int BIT_W = $clog2(WORD_W);
   localparam int IDX_W = SEL_W + BIT_W;
   localparam int CNT_W = $clog2(MAC_BYTES + 1);

   logic [31:0]      crc_q, crc_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             grp_q, grp_d;
   logic             last;
   logic [IDX_W-1:0] idx;
   logic [IDX_W-1:0] pos;
   logic             hit;

   always_comb begin
      crc_d = crc_q;
      cnt_d = cnt_q;
      grp_d = grp_q;
      last  = 1'b0;
      if (rx_valid && rx_sof) begin
         crc_d = crc_step(CRC_SEED, rx_byte);
         cnt_d = CNT_W'(1);
         grp_d = rx_byte[0];
         last  = (MAC_BYTES == 1);
      end else if (rx_valid && (cnt_q < CNT_W'(MAC_BYTES))) begin
         crc_d = crc_step(crc_q, rx_byte);
         cnt_d = cnt_q + CNT_W'(1);
         last  = (cnt_q == CNT_W'(MAC_BYTES - 1));
      end
   end

   for (genvar k = 0; k < IDX_W; k++) begin : g_rev
      assign idx[IDX_W-1-k] = crc_d[k];
   end

   // Word in the upper bits, MSB-first bit number in the lower bits.
   assign pos = {idx[IDX_W-1 -: SEL_W], ~idx[BIT_W-1:0]};
   assign hit = tbl_flat[pos];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         crc_q     <= CRC_SEED;
         cnt_q     <= CNT_W'(MAC_BYTES);
         grp_q     <= 1'b0;
         dec_valid <= 1'b0;
         accept    <= 1'b0;
      end else begin
         crc_q     <= crc_d;
         cnt_q     <= cnt_d;
         grp_q     <= grp_d;
         dec_valid <= last;
         accept    <= last && grp_d && hit;
      end
   end
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
   import mhf_pkg::*;
#(
   parameter int NUM_WORDS = 8,
   parameter int WORD_W    = 32
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               reg_cmd_valid,
   input  logic [1:0]                         reg_cmd_op,
   input  logic [$clog2(NUM_WORDS)-1:0]       reg_cmd_sel,
   input  logic [WORD_W-1:0]                  reg_cmd_data,
   input  logic [$clog2(NUM_WORDS)-1:0]       reg_rd_sel,
   output logic [WORD_W-1:0]                  reg_rd_data,
   input  logic                               hash_upd_valid,
   input  logic                               hash_upd_set,
   input  logic [8*MAC_BYTES-1:0]             hash_upd_mac,
   input  logic                               rx_valid,
   input  logic                               rx_sof,
   input  logic [7:0]                         rx_byte,
   output logic                               rx_dec_valid,
   output logic                               rx_accept
);
   localparam int ENTRIES = NUM_WORDS * WORD_W;
   localparam int IDX_W   = $clog2(ENTRIES);

   if ((NUM_WORDS < 2) || ((NUM_WORDS & (NUM_WORDS - 1)) != 0)) begin : g_chk_words
      $error("NUM_WORDS must be a power of two of at least 2");
   end
   if ((WORD_W < 2) || ((WORD_W & (WORD_W - 1)) != 0)) begin : g_chk_width
      $error("WORD_W must be a power of two of at least 2");
   end
   if (IDX_W > 32) begin : g_chk_idx
      $error("table larger than the CRC can index");
   end

   logic [IDX_W-1:0]   upd_idx;
   logic [ENTRIES-1:0] tbl_flat;

   mhf_hasher #(.IDX_W(IDX_W)) u_hasher (
      .mac (hash_upd_mac),
      .idx (upd_idx)
   );

   mhf_table #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (reg_cmd_valid),
      .cmd_op    (reg_cmd_op),
      .cmd_sel   (reg_cmd_sel),
      .cmd_data  (reg_cmd_data),
      .upd_valid (hash_upd_valid),
      .upd_set   (hash_upd_set),
      .upd_idx   (upd_idx),
      .rd_sel    (reg_rd_sel),
      .rd_data   (reg_rd_data),
      .tbl_flat  (tbl_flat)
   );

   mhf_rx #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_valid  (rx_valid),
      .rx_sof    (rx_sof),
      .rx_byte   (rx_byte),
      .tbl_flat  (tbl_flat),
      .dec_valid (rx_dec_valid),
      .accept    (rx_accept)
   );
endmodule

// File: rtl/mhf_checker.sv
module mhf_checker #(
   parameter int NUM_WORDS = 8,
   parameter int WORD_W    = 32
) (
   input logic                                 clk,
   input logic                                 rst_n,
   input logic                                 reg_cmd_valid,
   input logic [1:0]                           reg_cmd_op,
   input logic [$clog2(NUM_WORDS)-1:0]         reg_cmd_sel,
   input logic [WORD_W-1:0]                    reg_cmd_data,
   input logic                                 hash_upd_valid,
   input logic                                 hash_upd_set,
   input logic [$clog2(NUM_WORDS*WORD_W)-1:0]  upd_idx,
   input logic [NUM_WORDS*WORD_W-1:0]          tbl_flat,
   input logic                                 rx_dec_valid,
   input logic                                 rx_accept
);
   localparam int SEL_W = $clog2(NUM_WORDS);
   localparam int BIT_W = $clog2(WORD_W);
   localparam int IDX_W = SEL_W + BIT_W;

   logic [IDX_W-1:0] upd_pos;
   logic             same_word;

   assign upd_pos   = {upd_idx[IDX_W-1 -: SEL_W], ~upd_idx[BIT_W-1:0]};
   assign same_word = reg_cmd_valid && (reg_cmd_sel == upd_idx[IDX_W-1 -: SEL_W]);

   function automatic logic [WORD_W-1:0] word_at(input logic [NUM_WORDS*WORD_W-1:0] f,
                                                 input logic [SEL_W-1:0] s);
      return f[int'(s)*WORD_W +: WORD_W];
   endfunction

   p_set_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hash_upd_valid && hash_upd_set && !same_word |=> tbl_flat[$past(upd_pos)])
      else $error("hash set did not land");

   p_clear_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hash_upd_valid && !hash_upd_set && !same_word |=> !tbl_flat[$past(upd_pos)])
      else $error("hash clear did not land");

   p_or_keeps_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_cmd_valid && (reg_cmd_op == 2'b01)
      |=> ((word_at(tbl_flat, $past(reg_cmd_sel)) & $past(reg_cmd_data)) == $past(reg_cmd_data)))
      else $error("OR command lost mask bits");

   p_write_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      reg_cmd_valid && (reg_cmd_op == 2'b00)
      |=> (word_at(tbl_flat, $past(reg_cmd_sel)) == $past(reg_cmd_data)))
      else $error("register write not exact");

   p_dec_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_dec_valid |=> !rx_dec_valid)
      else $error("decision pulse longer than one cycle");

   p_acc_qual_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_accept |-> rx_dec_valid)
      else $error("accept without decision");
endmodule

bind mcast_hash_filter mhf_checker #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .reg_cmd_valid  (reg_cmd_valid),
   .reg_cmd_op     (reg_cmd_op),
   .reg_cmd_sel    (reg_cmd_sel),
   .reg_cmd_data   (reg_cmd_data),
   .hash_upd_valid (hash_upd_valid),
   .hash_upd_set   (hash_upd_set),
   .upd_idx        (upd_idx),
   .tbl_flat       (tbl_flat),
   .rx_dec_valid   (rx_dec_valid),
   .rx_accept      (rx_accept)
);

// File: tb/mcast_hash_filter_tb.sv
`timescale 1ns/1ps
module mcast_hash_filter_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_cmd_valid;
   logic [1:0]  reg_cmd_op;
   logic [2:0]  reg_cmd_sel;
   logic [31:0] reg_cmd_data;
   logic [2:0]  reg_rd_sel;
   logic [31:0] reg_rd_data;
   logic        hash_upd_valid;
   logic        hash_upd_set;
   logic [47:0] hash_upd_mac;
   logic        rx_valid;
   logic        rx_sof;
   logic [7:0]  rx_byte;
   logic        rx_dec_valid;
   logic        rx_accept;

   always #2.5 clk = ~clk;

   mcast_hash_filter u_dut (.*);

   int          n_chk = 0;
   int          n_fail = 0;
   int          n_dec = 0;
   int          n_sent = 0;
   logic [31:0] model [8];
   bit          exp_q [$];

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // Reference hash from R1.
   function automatic logic [7:0] ref_idx(input logic [47:0] mac);
      logic [31:0] c;
      logic [7:0]  b;
      logic [7:0]  ix;
      c = 32'hFFFF_FFFF;
      for (int n = 0; n < 6; n++) begin
         b = mac[8*(5-n) +: 8];
         for (int i = 0; i < 8; i++) begin
            if (c[31] ^ b[i]) c = {c[30:0], 1'b0} ^ 32'h04C1_1DB7;
            else              c = {c[30:0], 1'b0};
         end
      end
      for (int k = 0; k < 8; k++) ix[7-k] = c[k];
      return ix;
   endfunction

   function automatic logic [31:0] bit_mask(input logic [7:0] ix);
      return 32'h1 << (31 - ix[4:0]);
   endfunction

   task automatic model_hash(input logic [47:0] mac, input bit set);
      logic [7:0] ix;
      ix = ref_idx(mac);
      if (set) model[ix[7:5]] = model[ix[7:5]] | bit_mask(ix);
      else     model[ix[7:5]] = model[ix[7:5]] & ~bit_mask(ix);
   endtask

   task automatic model_cmd(input logic [1:0] op, input logic [2:0] sel, input logic [31:0] d);
      case (op)
         2'b00:   model[sel] = d;
         2'b01:   model[sel] = model[sel] | d;
         2'b10:   model[sel] = model[sel] & ~d;
         default: ;
      endcase
   endtask

   task automatic idle_all();
      reg_cmd_valid = 0; reg_cmd_op = 0; reg_cmd_sel = 0; reg_cmd_data = 0;
      hash_upd_valid = 0; hash_upd_set = 0; hash_upd_mac = 0;
      rx_valid = 0; rx_sof = 0; rx_byte = 0;
   endtask

   task automatic read_chk(input logic [2:0] sel, input string req);
      @(negedge clk);
      reg_rd_sel = sel;
      #0.5;
      check(req, reg_rd_data, model[sel]);
   endtask

   task automatic read_all(input string req);
      for (int w = 0; w < 8; w++) read_chk(3'(w), req);
   endtask

   task automatic hash_upd(input logic [47:0] mac, input bit set);
      @(negedge clk);
      hash_upd_valid = 1; hash_upd_set = set; hash_upd_mac = mac;
      @(negedge clk);
      hash_upd_valid = 0;
      model_hash(mac, set);
   endtask

   task automatic reg_cmd(input logic [1:0] op, input logic [2:0] sel, input logic [31:0] d);
      @(negedge clk);
      reg_cmd_valid = 1; reg_cmd_op = op; reg_cmd_sel = sel; reg_cmd_data = d;
      @(negedge clk);
      reg_cmd_valid = 0;
      model_cmd(op, sel, d);
   endtask

   // Same-cycle register command and hash update (R6).
   task automatic both(input logic [1:0] op, input logic [2:0] sel, input logic [31:0] d,
                       input logic [47:0] mac, input bit set);
      logic [7:0] ix;
      ix = ref_idx(mac);
      @(negedge clk);
      reg_cmd_valid = 1; reg_cmd_op = op; reg_cmd_sel = sel; reg_cmd_data = d;
      hash_upd_valid = 1; hash_upd_set = set; hash_upd_mac = mac;
      @(negedge clk);
      reg_cmd_valid = 0; hash_upd_valid = 0;
      model_cmd(op, sel, d);
      if (ix[7:5] != sel) model_hash(mac, set);
   endtask

   // Driver: pushes the expected decision, then streams the address.
   task automatic send_frame(input logic [47:0] mac, input bit gap);
      logic [7:0] ix;
      ix = ref_idx(mac);
      exp_q.push_back(mac[40] && ((model[ix[7:5]] & bit_mask(ix)) != 0));
      n_sent++;
      for (int n = 0; n < 6; n++) begin
         @(negedge clk);
         rx_valid = 1; rx_sof = (n == 0); rx_byte = mac[8*(5-n) +: 8];
         if (gap && n == 2) begin
            @(negedge clk);
            rx_valid = 0; rx_sof = 0; rx_byte = 8'hA5;
         end
      end
      @(negedge clk);
      rx_valid = 0; rx_sof = 0;
   endtask

   task automatic stray_bytes(input int count);
      for (int n = 0; n < count; n++) begin
         @(negedge clk);
         rx_valid = 1; rx_sof = 0; rx_byte = 8'(8'h11 * (n + 1)) | 8'h01;
      end
      @(negedge clk);
      rx_valid = 0;
   endtask

   // Monitor: pops the scoreboard on each decision pulse (R9, R10).
   always @(negedge clk) begin
      if (rst_n === 1'b1) begin
         if (rx_accept && !rx_dec_valid)
            check("R9 accept without decision", 32'(rx_accept), 32'(0));
         if (rx_dec_valid) begin
            n_dec++;
            if (exp_q.size() == 0) begin
               check("R8 unexpected decision", 32'(1), 32'(0));
            end else begin
               bit e;
               e = exp_q.pop_front();
               check("R10 accept", 32'(rx_accept), 32'(e));
            end
         end
      end
   end

   initial begin
      #(5.0 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   localparam logic [47:0] M1 = 48'h01005E000001;
   localparam logic [47:0] M2 = 48'h01005E7F1234;
   localparam logic [47:0] M3 = 48'h333300000001;
   localparam logic [47:0] M4 = 48'h0180C2000000;
   localparam logic [47:0] U1 = 48'h001122334455;

   initial begin
      logic [7:0] ix4;
      for (int w = 0; w < 8; w++) model[w] = '0;
      idle_all();
      reg_rd_sel = 0;
      rst_n = 0;
      repeat (4) @(negedge clk);
      rst_n = 1;

      // R7: reset state of table and decision outputs
      read_all("R7 reset word");
      check("R9 no decision after reset", 32'(rx_dec_valid), 32'(0));

      // R8: bytes before any start strobe are ignored
      stray_bytes(8);

      // R10: empty table rejects
      send_frame(M1, 0);

      // R1 R2 R3: set by hash, verify word contents and acceptance
      hash_upd(M1, 1);
      read_chk(ref_idx(M1) >> 5, "R2 R3 set M1");
      send_frame(M1, 0);
      hash_upd(M2, 1);
      hash_upd(M3, 1);
      read_all("R1 R3 table after sets");
      send_frame(M2, 1);   // R8 stall inside the address
      send_frame(M3, 0);
      send_frame(M4, 0);

      // R10: unicast address rejected even with its entry set
      hash_upd(U1, 1);
      read_chk(ref_idx(U1) >> 5, "R3 set unicast entry");
      send_frame(U1, 0);

      // R4: clear
      hash_upd(M1, 0);
      read_all("R4 table after clear");
      send_frame(M1, 0);

      // R5: register commands
      reg_cmd(2'b00, 3'd5, 32'hA5A5_5A5A);
      read_chk(3'd5, "R5 write");
      reg_cmd(2'b01, 3'd5, 32'h0000_00F0);
      read_chk(3'd5, "R5 or");
      reg_cmd(2'b10, 3'd5, 32'hA000_0001);
      read_chk(3'd5, "R5 andn");
      reg_cmd(2'b11, 3'd5, 32'hFFFF_FFFF);
      read_chk(3'd5, "R5 nop");

      // R6: same-word collision, register wins
      ix4 = ref_idx(M4);
      both(2'b00, ix4[7:5], 32'h0, M4, 1);
      read_all("R6 same word");
      send_frame(M4, 0);
      // R6: different words, both apply
      both(2'b01, ix4[7:5] ^ 3'd1, 32'h0000_0001, M4, 1);
      read_all("R6 different words");

      // R8: trailing bytes after the sixth are ignored
      send_frame(M4, 0);
      stray_bytes(5);

      // back-to-back frames
      send_frame(M2, 0);
      send_frame(M3, 0);

      repeat (6) @(negedge clk);
      check("R8 pending decisions", 32'(exp_q.size()), 32'(0));
      check("R9 decision count", 32'(n_dec), 32'(n_sent));
      report();
   end
endmodule